// File: doc/BRIEF.md
# Serial Input Edge-Event Interrupt Controller

This block sits behind a serial shift engine that periodically samples up to 64 remote input lines and hands over each completed sample as one parallel frame. It compares every accepted frame with the one before it and turns the per-bit changes into events. Each input has its own 2-bit event selector, so it can watch for rises, falls, either, or nothing. A selected event latches a sticky status bit, and one interrupt line is asserted while any status bit is set. Software clears a status bit by writing 1 to it.

The inputs are grouped into banks of eight. Each bank has one 16-bit selector register and one 8-bit status register. A small tracking state machine controls edge detection. It has three states:
- **OFF**: the interface is disabled and frames are ignored.
- **PRIME**: the interface is enabled, but no reference frame has been taken yet.
- **ARMED**: every accepted frame is compared with the stored reference.

Its transitions are:
- **OFF → PRIME** when the enable input goes high.
- **PRIME → ARMED** when the first frame strobe arrives while enabled.
- **PRIME → OFF** and **ARMED → OFF** whenever the enable input drops.

A separate programmed port count limits how many banks can raise events.

Top module: `sgev_ctrl`

## Requirements
- R1: After reset, every selector register reads 0x0000, every status register reads 0x00, and `irq` is 0.
- R2: The selector register of bank b is written and read at byte address 0x10 + 2·b. Input n of that bank uses selector bits [2n+1:2n]. Input n of bank b is `frame_data[8·b + n]`.
- R3: Selector code 2'b01 flags a 0→1 change, 2'b10 flags a 1→0 change, 2'b11 flags either change, and 2'b00 flags nothing.
- R4: A change is measured only between two frames accepted with `frame_valid` high. Activity on `frame_data` while `frame_valid` is low has no effect, and a frame equal to the previous one raises no event.
- R5: The status register of bank b is read at byte address 0x20 + b, in the low 8 bits of `rd_data`. A set bit stays set until a write to that address has a 1 in its position. Written 0 bits leave status unchanged.
- R6: If a status clear and a new event for the same bit land in the same cycle, the bit ends up set.
- R7: `irq` is high exactly when at least one status bit in any bank is set.
- R8: The first frame accepted after the enable rises only sets the reference and raises no event. This priming repeats after every disable and re-enable.
- R9: Only banks whose index is below `in_port_cnt` can set status bits. Frames still update the reference for the other banks.
- R10: While `if_enable` is low, frames raise no event.
- R11: A status bit sets in the clock edge that accepts the frame, and is visible in `rd_data` and `irq` right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| if_enable | input | 1 | Serial interface enable |
| frame_valid | input | 1 | One-cycle strobe: a new sample frame is complete |
| frame_data | input | 64 | Sampled input bits, bank b in bits [8b+7:8b] |
| in_port_cnt | input | 4 | Number of active input banks (0 to 8) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Register write byte address |
| wr_data | input | 16 | Write data (low byte for status registers) |
| rd_addr | input | 6 | Register read byte address |
| rd_data | output | 16 | Read data; unmapped addresses return 0 |
| irq | output | 1 | Combined event interrupt |

## Verification
The bench targets these corner cases:
- **The very first frame after enable.** A design that compares it with a stale or zero reference would set status bits as soon as the interface comes up.
- **A clear colliding with a new event on the same bit.** A design where the clear wins would silently lose events.
- **Changes on the data lines without a strobe.** A design that tracked the live lines would report edges that never formed a frame.
- **Banks outside the programmed port count, and frames received while disabled.** These must neither set status nor leave a false reference behind. A design that froze the reference for masked banks would raise a spurious event once the count is raised.

// File: rtl/sgev_pkg.sv
package sgev_pkg;

    typedef enum logic [1:0] {
        EV_NONE = 2'b00,
        EV_RISE = 2'b01,
        EV_FALL = 2'b10,
        EV_ANY  = 2'b11
    } ev_code_e;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_PRIME = 2'd1,
        ST_ARMED = 2'd2
    } trk_state_e;

    function automatic logic code_wants_rise(input ev_code_e c);
        return (c == EV_RISE) || (c == EV_ANY);
    endfunction

    function automatic logic code_wants_fall(input ev_code_e c);
        return (c == EV_FALL) || (c == EV_ANY);
    endfunction

endpackage

// File: rtl/sgev_frame_tracker.sv
module sgev_frame_tracker
    import sgev_pkg::*;
#(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         if_enable,
    input  logic         frame_valid,
    input  logic [W-1:0] frame_data,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);

    trk_state_e   state_q, state_d;
    logic [W-1:0] ref_q;
    logic         capture;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (if_enable) state_d = ST_PRIME;
            end
            ST_PRIME: begin
                if (!if_enable)       state_d = ST_OFF;
                else if (frame_valid) state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (!if_enable) state_d = ST_OFF;
            end
            default: state_d = ST_OFF;
        endcase
    end

    // outputs
    always_comb begin
        capture = 1'b0;
        rise_o  = '0;
        fall_o  = '0;
        unique case (state_q)
            ST_OFF: begin
                capture = 1'b0;
            end
            ST_PRIME: begin
                capture = if_enable && frame_valid;
            end
            ST_ARMED: begin
                if (if_enable && frame_valid) begin
                    capture = 1'b1;
                    rise_o  = frame_data & ~ref_q;
                    fall_o  = ~frame_data & ref_q;
                end
            end
            default: capture = 1'b0;
        endcase
    end

    // reference frame
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ref_q <= '0;
        else if (capture) ref_q <= frame_data;
    end

    AST_DISABLE_TO_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !if_enable |=> (state_q == ST_OFF)); // R10

    AST_ARM_AFTER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED && $past(state_q) != ST_ARMED) |-> $past(frame_valid)); // R8

endmodule

// File: rtl/sgev_bank.sv
module sgev_bank
    import sgev_pkg::*;
#(
    parameter int BW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bank_on,
    input  logic            cfg_we,
    input  logic [2*BW-1:0] cfg_wdata,
    input  logic [BW-1:0]   sts_clr,
    input  logic [BW-1:0]   rise_i,
    input  logic [BW-1:0]   fall_i,
    output logic [2*BW-1:0] cfg_o,
    output logic [BW-1:0]   sts_o
);

    localparam int CW = 2 * BW;

    logic [CW-1:0] cfg_q;
    logic [BW-1:0] sts_q;
    logic [BW-1:0] hit;

    for (genvar i = 0; i < BW; i++) begin : g_bit
        ev_code_e code;
        assign code   = ev_code_e'(cfg_q[2*i +: 2]);
        assign hit[i] = bank_on &&
                        ((rise_i[i] && code_wants_rise(code)) ||
                         (fall_i[i] && code_wants_fall(code)));

        AST_STS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (sts_q[i] && !sts_clr[i]) |=> sts_q[i]); // R5

        AST_SET_NEEDS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(sts_q[i]) |-> ($past(cfg_q[2*i +: 2]) != 2'b00)); // R3
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cfg_q <= '0;
        else if (cfg_we) cfg_q <= cfg_wdata;
    end

    // event beats clear on the same bit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sts_q <= '0;
        else        sts_q <= (sts_q & ~sts_clr) | hit;
    end

    assign cfg_o = cfg_q;
    assign sts_o = sts_q;

    AST_MASKED_BANK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !bank_on |=> ((sts_q & ~$past(sts_q)) == '0)); // R9

endmodule

// File: rtl/sgev_regdec.sv
module sgev_regdec #(
    parameter int BANKS    = 8,
    parameter int BW       = 8,
    parameter int ADDR_W   = 6,
    parameter int CFG_BASE = 16,
    parameter int STS_BASE = 32
) (
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic [2*BW-1:0]        wr_data,
    input  logic [ADDR_W-1:0]      rd_addr,
    input  logic [BANKS*2*BW-1:0]  cfg_all,
    input  logic [BANKS*BW-1:0]    sts_all,
    output logic [BANKS-1:0]       cfg_we,
    output logic [BANKS*BW-1:0]    sts_clr,
    output logic [2*BW-1:0]        rd_data
);

    localparam int CW = 2 * BW;

    for (genvar b = 0; b < BANKS; b++) begin : g_dec
        localparam logic [ADDR_W-1:0] CFG_A = ADDR_W'(CFG_BASE + 2 * b);
        localparam logic [ADDR_W-1:0] STS_A = ADDR_W'(STS_BASE + b);
        assign cfg_we[b]           = wr_en && (wr_addr == CFG_A);
        assign sts_clr[b*BW +: BW] = (wr_en && (wr_addr == STS_A)) ? wr_data[BW-1:0] : '0;
    end

    always_comb begin
        rd_data = '0;
        for (int b = 0; b < BANKS; b++) begin
            if (rd_addr == ADDR_W'(CFG_BASE + 2 * b))
                rd_data = cfg_all[b*CW +: CW];
            if (rd_addr == ADDR_W'(STS_BASE + b))
                rd_data = {{(CW-BW){1'b0}}, sts_all[b*BW +: BW]};
        end
    end

endmodule

// File: rtl/sgev_ctrl.sv
module sgev_ctrl
    import sgev_pkg::*;
#(
    parameter int BANKS    = 8,
    parameter int BANK_W   = 8,
    parameter int ADDR_W   = 6,
    parameter int CFG_BASE = 16,
    parameter int STS_BASE = 32,
    parameter int PCNT_W   = $clog2(BANKS + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     if_enable,
    input  logic                     frame_valid,
    input  logic [BANKS*BANK_W-1:0]  frame_data,
    input  logic [PCNT_W-1:0]        in_port_cnt,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [2*BANK_W-1:0]      wr_data,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic [2*BANK_W-1:0]      rd_data,
    output logic                     irq
);

    localparam int NIN = BANKS * BANK_W;
    localparam int CW  = 2 * BANK_W;

    logic [NIN-1:0]      rise, fall;
    logic [BANKS*CW-1:0] cfg_all;
    logic [NIN-1:0]      sts_all;
    logic [NIN-1:0]      sts_clr;
    logic [BANKS-1:0]    cfg_we;

    sgev_frame_tracker #(.W(NIN)) u_trk (
        .clk         (clk),
        .rst_n       (rst_n),
        .if_enable   (if_enable),
        .frame_valid (frame_valid),
        .frame_data  (frame_data),
        .rise_o      (rise),
        .fall_o      (fall)
    );

    sgev_regdec #(
        .BANKS(BANKS), .BW(BANK_W), .ADDR_W(ADDR_W),
        .CFG_BASE(CFG_BASE), .STS_BASE(STS_BASE)
    ) u_dec (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .cfg_all (cfg_all),
        .sts_all (sts_all),
        .cfg_we  (cfg_we),
        .sts_clr (sts_clr),
        .rd_data (rd_data)
    );

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        logic bank_on;
        assign bank_on = (in_port_cnt > PCNT_W'(b));

        sgev_bank #(.BW(BANK_W)) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .bank_on   (bank_on),
            .cfg_we    (cfg_we[b]),
            .cfg_wdata (wr_data),
            .sts_clr   (sts_clr[b*BANK_W +: BANK_W]),
            .rise_i    (rise[b*BANK_W +: BANK_W]),
            .fall_i    (fall[b*BANK_W +: BANK_W]),
            .cfg_o     (cfg_all[b*CW +: CW]),
            .sts_o     (sts_all[b*BANK_W +: BANK_W])
        );
    end

    assign irq = |sts_all;

    AST_IRQ_FROM_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(frame_valid && if_enable)); // R7

    AST_IRQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !wr_en) |=> irq); // R5

endmodule

// File: tb/sgev_ctrl_tb_top.sv
module sgev_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        if_enable;
    logic        frame_valid;
    logic [63:0] frame_data;
    logic [3:0]  in_port_cnt;
    logic        wr_en;
    logic [5:0]  wr_addr;
    logic [15:0] wr_data;
    logic [5:0]  rd_addr;
    logic [15:0] rd_data;
    logic        irq;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    sgev_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .if_enable(if_enable),
        .frame_valid(frame_valid), .frame_data(frame_data),
        .in_port_cnt(in_port_cnt), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
    );

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic rd(input logic [5:0] a, output logic [15:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic wr(input logic [5:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic frame(input logic [63:0] d);
        @(negedge clk);
        frame_valid = 1'b1; frame_data = d;
        @(negedge clk);
        frame_valid = 1'b0;
    endtask

    task automatic frame_and_clear(input logic [63:0] d, input logic [5:0] a, input logic [15:0] w);
        @(negedge clk);
        frame_valid = 1'b1; frame_data = d;
        wr_en = 1'b1; wr_addr = a; wr_data = w;
        @(negedge clk);
        frame_valid = 1'b0; wr_en = 1'b0;
    endtask

    task automatic t_reset;
        logic [15:0] v;
        rd(6'h10, v); chk("R1 cfg0 after reset", v, 16'h0000);
        rd(6'h1E, v); chk("R1 cfg7 after reset", v, 16'h0000);
        rd(6'h20, v); chk("R1 sts0 after reset", v, 16'h0000);
        chk("R1 irq after reset", {15'b0, irq}, 16'h0000);
    endtask

    task automatic t_cfg_map;
        logic [15:0] v;
        wr(6'h16, 16'hA5C3);
        rd(6'h16, v); chk("R2 cfg3 readback", v, 16'hA5C3);
        rd(6'h14, v); chk("R2 cfg2 untouched", v, 16'h0000);
        rd(6'h15, v); chk("R2 odd address unmapped", v, 16'h0000);
    endtask

    task automatic t_prime_and_rise;
        logic [15:0] v;
        wr(6'h10, 16'h5555);
        @(negedge clk); if_enable = 1'b1;
        @(negedge clk);
        frame(64'h0000_0000_0000_00FF);
        rd(6'h20, v); chk("R8 first frame quiet", v, 16'h0000);
        frame(64'h0);
        rd(6'h20, v); chk("R3 fall ignored by rise code", v, 16'h0000);
        frame(64'h0000_0000_0000_000F);
        rd(6'h20, v); chk("R11 rise sets status at accept edge", v, 16'h000F);
        chk("R7 irq set", {15'b0, irq}, 16'h0001);
    endtask

    task automatic t_w1c;
        logic [15:0] v;
        wr(6'h20, 16'h0003);
        rd(6'h20, v); chk("R5 clear by ones", v, 16'h000C);
        wr(6'h20, 16'h0000);
        rd(6'h20, v); chk("R5 zero write no effect", v, 16'h000C);
        wr(6'h20, 16'h000C);
        rd(6'h20, v); chk("R5 cleared", v, 16'h0000);
        chk("R7 irq low when all clear", {15'b0, irq}, 16'h0000);
    endtask

    task automatic t_fall;
        logic [15:0] v;
        wr(6'h12, 16'hAAAA);
        frame(64'h0000_0000_0000_FF0F);
        rd(6'h21, v); chk("R3 rise ignored by fall code", v, 16'h0000);
        frame(64'h0000_0000_0000_0F0F);
        rd(6'h21, v); chk("R3 fall code", v, 16'h00F0);
        rd(6'h20, v); chk("R4 unchanged bank quiet", v, 16'h0000);
        wr(6'h21, 16'h00FF);
        chk("R7 irq after clear", {15'b0, irq}, 16'h0000);
    endtask

    task automatic t_mixed;
        logic [15:0] v;
        wr(6'h14, 16'h0027);
        frame(64'h0000_0000_000F_0F0F);
        rd(6'h22, v); chk("R3 mixed codes on rise", v, 16'h0003);
        wr(6'h22, 16'h00FF);
        frame(64'h0000_0000_0000_0F0F);
        rd(6'h22, v); chk("R3 mixed codes on fall", v, 16'h0005);
        wr(6'h22, 16'h00FF);
    endtask

    task automatic t_no_strobe;
        logic [15:0] v;
        @(negedge clk); frame_data = 64'hFFFF_FFFF_FFFF_FFFF;
        repeat (5) @(negedge clk);
        chk("R4 no strobe no event", {15'b0, irq}, 16'h0000);
        frame(64'h0000_0000_0000_0F0F);
        rd(6'h20, v); chk("R4 equal frame quiet b0", v, 16'h0000);
        chk("R4 equal frame irq", {15'b0, irq}, 16'h0000);
    endtask

    task automatic t_collision;
        logic [15:0] v;
        frame_and_clear(64'h0000_0000_0000_0FFF, 6'h20, 16'h00FF);
        rd(6'h20, v); chk("R6 event wins over clear", v, 16'h00F0);
        wr(6'h20, 16'h00F0);
    endtask

    task automatic t_port_count;
        logic [15:0] v;
        @(negedge clk); in_port_cnt = 4'd2;
        wr(6'h16, 16'h5555);
        frame(64'h0000_0000_FF00_0FFF);
        rd(6'h23, v); chk("R9 masked bank quiet", v, 16'h0000);
        chk("R9 masked bank irq", {15'b0, irq}, 16'h0000);
        @(negedge clk); in_port_cnt = 4'd4;
        frame(64'h0000_0000_FF00_0FFF);
        rd(6'h23, v); chk("R9 reference tracked while masked", v, 16'h0000);
        frame(64'h0000_0000_0000_0FFF);
        frame(64'h0000_0000_FF00_0FFF);
        rd(6'h23, v); chk("R9 bank enabled", v, 16'h00FF);
        chk("R7 irq from bank3", {15'b0, irq}, 16'h0001);
        wr(6'h23, 16'h00FF);
    endtask

    task automatic t_disable;
        logic [15:0] v;
        frame(64'h0000_0000_0000_0F00);
        @(negedge clk); if_enable = 1'b0;
        @(negedge clk);
        frame(64'h0000_0000_0000_0FFF);
        rd(6'h20, v); chk("R10 disabled frame ignored", v, 16'h0000);
        frame(64'h0000_0000_0000_0F00);
        @(negedge clk); if_enable = 1'b1;
        @(negedge clk);
        frame(64'h0000_0000_0000_0FFF);
        rd(6'h20, v); chk("R8 re-prime after enable", v, 16'h0000);
        frame(64'h0000_0000_0000_0F00);
        frame(64'h0000_0000_0000_0FFF);
        rd(6'h20, v); chk("R8 armed after prime", v, 16'h00FF);
        wr(6'h20, 16'h00FF);
        chk("R7 irq clear at end", {15'b0, irq}, 16'h0000);
    endtask

    initial begin
        #200000;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; if_enable = 1'b0; frame_valid = 1'b0; frame_data = '0;
        in_port_cnt = 4'd8; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_cfg_map();
        t_prime_and_rise();
        t_w1c();
        t_fall();
        t_mixed();
        t_no_strobe();
        t_collision();
        t_port_count();
        t_disable();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule